// File: doc/BRIEF.md
# Interrupt Priority and Acknowledge Core

This block keeps the interrupt bookkeeping that sits beside a processor core. It owns three vector-wide bitmaps: pending requests, vectors currently being serviced, and the trigger kind of each vector. It also holds a task priority set by software and a spurious-vector word that carries the software enable. From these it derives a processor priority and drives a single request line to the CPU.

A source presents a vector and a trigger kind on the accept port to mark that vector pending. When the CPU takes the interrupt, it pulses the acknowledge strobe. One cycle later the block returns either the highest pending vector, which it also moves into service, or the spurious vector. An end-of-interrupt pulse retires the highest vector in service. The block then reports, for one cycle, whether that vector was level-triggered. An INIT strobe returns the interrupt state to its power-on form while software settings of task priority survive.

Top module: `irq_prio_core`

## Requirements
- R1: After reset, irq is 0, ppr is 0x00, ack_vector is 0x00, eoi_level is 0, task priority is 0, the spurious word is 0x0FF (software enable bit 8 clear), and the pending, in-service and trigger sets are empty.
- R2: A cycle with acc_valid high sets the pending bit of acc_vector. It records acc_level as that vector's trigger kind (1 = level, 0 = edge); a later accept of the same vector overwrites the kind.
- R3: Every search of a set selects the highest-numbered set bit, and an empty set yields "none".
- R4: irq is high only when bit 8 of the spurious word is 1 and at least one vector is pending.
- R5: When ppr is nonzero, irq is held low if bits 7:4 of the highest pending vector are less than or equal to bits 7:4 of ppr.
- R6: On ack_req, if the request qualifies, the highest pending vector's pending bit is cleared and its in-service bit is set. That vector appears on ack_vector from the next cycle and holds until the next acknowledge.
- R7: ack_req returns the spurious word bits 7:0 and leaves the sets untouched in three cases: task priority is nonzero and the highest pending vector is less than or equal to it, software enable is clear, or nothing is pending.
- R8: eoi clears the highest in-service bit. For the next cycle, eoi_level is 1 exactly when that vector's recorded kind was level. With nothing in service, eoi changes nothing and eoi_level stays 0.
- R9: A tpr_wr stores tpr_data shifted left by 4 as the 8-bit task priority; a svr_wr stores all 9 bits of svr_data as the spurious word.
- R10: ppr equals task priority when bits 7:4 of task priority are greater than or equal to bits 7:4 of the highest in-service vector, or when nothing is in service. Otherwise ppr is that vector with bits 3:0 cleared.
- R11: init_rst empties all three sets and sets the spurious word to 0x0FF. Task priority and ack_vector are kept, and every other strobe in that cycle is ignored.
- R12: Within one cycle, acknowledge and EOI decisions use the state before the edge. EOI's clear is applied before acknowledge's set, and acknowledge's pending clear is applied before an accept's set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Accept a vector this cycle |
| acc_vector | input | 8 | Vector being accepted |
| acc_level | input | 1 | Trigger kind of accepted vector, 1 = level |
| ack_req | input | 1 | CPU acknowledge strobe |
| eoi | input | 1 | End-of-interrupt strobe |
| tpr_wr | input | 1 | Task priority write strobe |
| tpr_data | input | 4 | Task priority class to store |
| svr_wr | input | 1 | Spurious word write strobe |
| svr_data | input | 9 | Spurious word: bit 8 enable, bits 7:0 vector |
| init_rst | input | 1 | INIT reset strobe |
| irq | output | 1 | Interrupt request to the CPU |
| ack_vector | output | 8 | Vector returned by the last acknowledge |
| ppr | output | 8 | Processor priority |
| eoi_level | output | 1 | One-cycle flag: retired vector was level-triggered |

## Verification
Acknowledge and end-of-interrupt can fall in the same cycle as an accept, and all three can collide with INIT. The nastiest cases are an accept of the very vector being acknowledged, and an EOI on a vector whose pending copy is acknowledged at the same edge. These are provoked by directed cycles that stack the strobes on one vector. A random phase then draws vectors from a small pool so that collisions recur. A behavioural model applies the R12 ordering and is compared with irq, ppr, ack_vector and eoi_level after every edge. Any overlap resolved in the wrong order shows up as a pending bit that is lost or kept, and that difference reaches irq or a later acknowledge.

// File: rtl/irq_core_pkg.sv
package irq_core_pkg;

    typedef enum logic {
        TRIG_EDGE  = 1'b0,
        TRIG_LEVEL = 1'b1
    } trig_e;

    typedef enum logic {
        ACK_SPURIOUS = 1'b0,
        ACK_TAKE     = 1'b1
    } ack_e;

endpackage

// File: rtl/irq_vec_find.sv
module irq_vec_find #(
    parameter  int NVEC = 256,
    parameter  int WORD = 32,
    localparam int IW   = $clog2(NVEC)
) (
    input  logic [NVEC-1:0] bits_i,
    output logic            found_o,
    output logic [IW-1:0]   idx_o
);
    localparam int NWORD = NVEC / WORD;
    localparam int BW    = $clog2(WORD);

    logic [NWORD-1:0]         w_any;
    logic [NWORD-1:0][BW-1:0] w_idx;

    // per-word search for the top set bit
    for (genvar g = 0; g < NWORD; g++) begin : g_word
        logic [WORD-1:0] w;
        logic [BW-1:0]   top;
        assign w = bits_i[g*WORD +: WORD];
        always_comb begin
            top = '0;
            for (int b = 0; b < WORD; b++) begin
                if (w[b]) top = BW'(b);
            end
        end
        assign w_any[g] = |w;
        assign w_idx[g] = top;
    end

    // highest non-empty word wins
    always_comb begin
        found_o = |w_any;
        idx_o   = '0;
        for (int k = 0; k < NWORD; k++) begin
            if (w_any[k]) idx_o = IW'(k * WORD + int'(w_idx[k]));
        end
    end
endmodule

// File: rtl/irq_prio_calc.sv
module irq_prio_calc #(
    parameter  int VW = 8,
    localparam int LO = VW - 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [VW-1:0] tpr_i,
    input  logic          isr_found_i,
    input  logic [VW-1:0] isr_idx_i,
    input  logic          irr_found_i,
    input  logic [VW-1:0] irr_idx_i,
    input  logic          enable_i,
    output logic [VW-1:0] ppr_o,
    output logic          irq_o
);
    always_comb begin
        if (!isr_found_i || tpr_i[VW-1:LO] >= isr_idx_i[VW-1:LO]) begin
            ppr_o = tpr_i;
        end else begin
            ppr_o = {isr_idx_i[VW-1:LO], {LO{1'b0}}};
        end
        irq_o = enable_i && irr_found_i &&
                !((ppr_o != '0) && (irr_idx_i[VW-1:LO] <= ppr_o[VW-1:LO]));
    end

    // R10: priority never below task priority, never below in-service class
    p_ppr_floor_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ppr_o >= tpr_i);
    p_ppr_cover_r10: assert property (@(posedge clk) disable iff (!rst_n)
        isr_found_i |-> ppr_o[VW-1:LO] >= isr_idx_i[VW-1:LO]);
    // R5: a raised request always beats the priority class
    p_irq_class_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && ppr_o != '0) |-> irr_idx_i[VW-1:LO] > ppr_o[VW-1:LO]);
endmodule

// File: rtl/irq_prio_core.sv
module irq_prio_core #(
    parameter  int NVEC = 256,
    parameter  int WORD = 32,
    localparam int VW   = $clog2(NVEC),
    localparam int LO   = VW - 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_valid,
    input  logic [VW-1:0] acc_vector,
    input  logic          acc_level,
    input  logic          ack_req,
    input  logic          eoi,
    input  logic          tpr_wr,
    input  logic [3:0]    tpr_data,
    input  logic          svr_wr,
    input  logic [VW:0]   svr_data,
    input  logic          init_rst,
    output logic          irq,
    output logic [VW-1:0] ack_vector,
    output logic [VW-1:0] ppr,
    output logic          eoi_level
);
    import irq_core_pkg::*;

    typedef struct packed {
        logic [NVEC-1:0] irr;
        logic [NVEC-1:0] isr;
        logic [NVEC-1:0] tmr;
        logic [VW-1:0]   tpr;
        logic [VW:0]     svr;
        logic [VW-1:0]   ack_vec;
        logic            eoi_lvl;
    } core_t;

    core_t r_q, r_d;

    logic          irr_found, isr_found;
    logic [VW-1:0] irr_idx, isr_idx;
    ack_e          ack_kind;

    irq_vec_find #(.NVEC(NVEC), .WORD(WORD)) u_find_irr (
        .bits_i (r_q.irr), .found_o(irr_found), .idx_o(irr_idx));
    irq_vec_find #(.NVEC(NVEC), .WORD(WORD)) u_find_isr (
        .bits_i (r_q.isr), .found_o(isr_found), .idx_o(isr_idx));

    irq_prio_calc #(.VW(VW)) u_prio (
        .clk        (clk),
        .rst_n      (rst_n),
        .tpr_i      (r_q.tpr),
        .isr_found_i(isr_found),
        .isr_idx_i  (isr_idx),
        .irr_found_i(irr_found),
        .irr_idx_i  (irr_idx),
        .enable_i   (r_q.svr[VW]),
        .ppr_o      (ppr),
        .irq_o      (irq)
    );

    always_comb begin
        r_d         = r_q;
        r_d.eoi_lvl = 1'b0;
        ack_kind    = (r_q.svr[VW] && irr_found &&
                       !((r_q.tpr != '0) && (irr_idx <= r_q.tpr))) ? ACK_TAKE : ACK_SPURIOUS;
        if (init_rst) begin
            r_d.irr = '0;
            r_d.isr = '0;
            r_d.tmr = '0;
            r_d.svr = {1'b0, {VW{1'b1}}};
        end else begin
            if (eoi && isr_found) begin
                r_d.isr[isr_idx] = 1'b0;
                r_d.eoi_lvl      = r_q.tmr[isr_idx];
            end
            if (ack_req) begin
                if (ack_kind == ACK_TAKE) begin
                    r_d.irr[irr_idx] = 1'b0;
                    r_d.isr[irr_idx] = 1'b1;
                    r_d.ack_vec      = irr_idx;
                end else begin
                    r_d.ack_vec = r_q.svr[VW-1:0];
                end
            end
            if (acc_valid) begin
                r_d.irr[acc_vector] = 1'b1;
                r_d.tmr[acc_vector] = (trig_e'(acc_level) == TRIG_LEVEL);
            end
            if (tpr_wr) r_d.tpr = {tpr_data, {LO{1'b0}}};
            if (svr_wr) r_d.svr = svr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.irr     <= '0;
            r_q.isr     <= '0;
            r_q.tmr     <= '0;
            r_q.tpr     <= '0;
            r_q.svr     <= {1'b0, {VW{1'b1}}};
            r_q.ack_vec <= '0;
            r_q.eoi_lvl <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign ack_vector = r_q.ack_vec;
    assign eoi_level  = r_q.eoi_lvl;

    // R4: request only with software enable
    p_irq_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> r_q.svr[VW]);
    // R2: accepted vector is pending with its trigger kind next cycle
    p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !init_rst) |=>
        (r_q.irr[$past(acc_vector)] && (r_q.tmr[$past(acc_vector)] == $past(acc_level))));
    // R7: disabled acknowledge returns the spurious byte
    p_ack_spur_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req && !init_rst && !r_q.svr[VW]) |=> ack_vector == $past(r_q.svr[VW-1:0]));
    // R6: a taken vector lands in service
    p_ack_take_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req && !init_rst && ack_kind == ACK_TAKE) |=>
        (r_q.isr[$past(irr_idx)] && ack_vector == $past(irr_idx)));
    // R8: retired vector leaves service unless re-taken in the same cycle
    p_eoi_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && !init_rst && isr_found && !(ack_req && ack_kind == ACK_TAKE && irr_idx == isr_idx))
        |=> !r_q.isr[$past(isr_idx)]);
    // R9: task priority stored shifted
    p_tpr_store_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tpr_wr && !init_rst) |=> r_q.tpr == {$past(tpr_data), {LO{1'b0}}});
    // R11: INIT leaves nothing requesting and priority equal to task priority
    p_init_r11: assert property (@(posedge clk) disable iff (!rst_n)
        init_rst |=> (!irq && ppr == r_q.tpr && !eoi_level));
endmodule

// File: tb/irq_prio_core_tb.sv
`timescale 1ns/1ps
module irq_prio_core_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_valid = 0, acc_level = 0, ack_req = 0, eoi = 0;
    logic       tpr_wr = 0, svr_wr = 0, init_rst = 0;
    logic [7:0] acc_vector = 0;
    logic [3:0] tpr_data = 0;
    logic [8:0] svr_data = 0;
    logic       irq, eoi_level;
    logic [7:0] ack_vector, ppr;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    // behavioural model
    bit m_irr[256];
    bit m_isr[256];
    bit m_tmr[256];
    int m_tpr, m_svr, m_ack, m_eoil;

    always #2 clk = ~clk;

    irq_prio_core u_dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_vector(acc_vector),
        .acc_level(acc_level), .ack_req(ack_req), .eoi(eoi), .tpr_wr(tpr_wr),
        .tpr_data(tpr_data), .svr_wr(svr_wr), .svr_data(svr_data), .init_rst(init_rst),
        .irq(irq), .ack_vector(ack_vector), .ppr(ppr), .eoi_level(eoi_level));

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic int top_irr();
        int v = -1;
        for (int i = 0; i < 256; i++) if (m_irr[i]) v = i;
        return v;
    endfunction

    function automatic int top_isr();
        int v = -1;
        for (int i = 0; i < 256; i++) if (m_isr[i]) v = i;
        return v;
    endfunction

    function automatic int m_ppr();
        int s = top_isr();
        if (s < 0 || (m_tpr >> 4) >= (s >> 4)) return m_tpr;
        return s & 'hF0;
    endfunction

    function automatic int m_irq();
        int v = top_irr();
        int p = m_ppr();
        if (((m_svr >> 8) & 1) == 0 || v < 0) return 0;
        if (p != 0 && (v >> 4) <= (p >> 4)) return 0;
        return 1;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 256; i++) begin m_irr[i] = 0; m_isr[i] = 0; m_tmr[i] = 0; end
        m_tpr = 0; m_svr = 'h0FF; m_ack = 0; m_eoil = 0;
    endtask

    // applies one edge of stimulus to the model, R12 ordering
    task automatic model_edge();
        int hv = top_irr();
        int sv = top_isr();
        bit take;
        m_eoil = 0;
        if (init_rst) begin
            for (int i = 0; i < 256; i++) begin m_irr[i] = 0; m_isr[i] = 0; m_tmr[i] = 0; end
            m_svr = 'h0FF;
            return;
        end
        take = ((m_svr >> 8) & 1) && hv >= 0 && !(m_tpr != 0 && hv <= m_tpr);
        if (eoi && sv >= 0) begin
            m_eoil = m_tmr[sv];
            m_isr[sv] = 0;
        end
        if (ack_req) begin
            if (take) begin m_irr[hv] = 0; m_isr[hv] = 1; m_ack = hv; end
            else m_ack = m_svr & 'hFF;
        end
        if (acc_valid) begin m_irr[acc_vector] = 1; m_tmr[acc_vector] = acc_level; end
        if (tpr_wr) m_tpr = int'(tpr_data) << 4;
        if (svr_wr) m_svr = int'(svr_data);
    endtask

    task automatic step(input bit av, input int vec, input bit lvl, input bit ak,
                        input bit eo, input bit tw, input int td, input bit sw,
                        input int sd, input bit ini);
        acc_valid = av; acc_vector = 8'(vec); acc_level = lvl; ack_req = ak; eoi = eo;
        tpr_wr = tw; tpr_data = 4'(td); svr_wr = sw; svr_data = 9'(sd); init_rst = ini;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        cyc++;
        acc_valid = 0; ack_req = 0; eoi = 0; tpr_wr = 0; svr_wr = 0; init_rst = 0;
        chk("R4/R5 irq", int'(irq), m_irq());
        chk("R10 ppr", int'(ppr), m_ppr());
        chk("R6/R7 ack_vector", int'(ack_vector), m_ack);
        chk("R8 eoi_level", int'(eoi_level), m_eoil);
    endtask

    task automatic idle(); step(0,0,0,0,0,0,0,0,0,0); endtask
    task automatic accept(input int v, input bit l); step(1,v,l,0,0,0,0,0,0,0); endtask
    task automatic ack(); step(0,0,0,1,0,0,0,0,0,0); endtask
    task automatic do_eoi(); step(0,0,0,0,1,0,0,0,0,0); endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        int seed = 7;
        void'($urandom(seed));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 irq", int'(irq), 0);
        chk("R1 ppr", int'(ppr), 0);
        chk("R1 ack_vector", int'(ack_vector), 0);
        chk("R1 eoi_level", int'(eoi_level), 0);

        // R4: pending but disabled -> no request; R7: ack returns 0xFF
        accept('h45, 0);
        chk("R4 disabled no irq", int'(irq), 0);
        ack();
        chk("R7 disabled spurious", int'(ack_vector), 'hFF);
        // R9 spurious word write enables
        step(0,0,0,0,0,0,0,1,'h13F,0);
        chk("R4 enabled irq", int'(irq), 1);
        accept('h30, 0);
        ack();
        chk("R3/R6 highest taken", int'(ack_vector), 'h45);
        chk("R10 ppr from isr", int'(ppr), 'h40);
        chk("R5 lower class held", int'(irq), 0);
        accept('h41, 0);
        chk("R5 equal class held", int'(irq), 0);
        accept('h52, 1);
        chk("R5 higher class raises", int'(irq), 1);
        ack();
        chk("R6 level vector taken", int'(ack_vector), 'h52);
        chk("R10 ppr nested", int'(ppr), 'h50);
        do_eoi();
        chk("R8 level retire flag", int'(eoi_level), 1);
        chk("R8 ppr back", int'(ppr), 'h40);
        do_eoi();
        chk("R8 edge retire flag", int'(eoi_level), 0);
        chk("R10 ppr empty isr", int'(ppr), 0);
        do_eoi();
        chk("R8 eoi none in service", int'(eoi_level), 0);
        // R9 task priority write
        step(0,0,0,0,0,1,4,0,0,0);
        chk("R9 tpr shifted", int'(ppr), 'h40);
        chk("R5 tpr class blocks", int'(irq), 0);
        ack();
        chk("R7 vector above tpr taken", int'(ack_vector), 'h41);
        step(0,0,0,0,0,1,5,0,0,0);
        ack();
        chk("R7 below tpr spurious", int'(ack_vector), 'h3F);
        do_eoi();
        step(0,0,0,0,0,1,0,0,0,0);
        chk("R7 spurious left pending", int'(irq), 1);
        ack();
        chk("R7 pending kept", int'(ack_vector), 'h30);
        do_eoi();
        // R2 trigger kind overwritten
        accept('hA0, 1);
        accept('hA0, 0);
        ack();
        do_eoi();
        chk("R2 kind overwritten", int'(eoi_level), 0);
        // R12 accept of acknowledged vector in the same cycle
        accept('h60, 1);
        step(1,'h60,1,1,0,0,0,0,0,0);
        chk("R12 ack vs accept", int'(ack_vector), 'h60);
        do_eoi();
        chk("R12 re-accepted pending", int'(irq), 1);
        // R12 eoi and ack of the same vector
        step(1,'h60,0,0,0,0,0,0,0,0);
        step(0,0,0,1,0,0,0,0,0,0);
        accept('h60, 0);
        step(0,0,0,1,1,0,0,0,0,0);
        chk("R12 eoi then ack", int'(ppr), 'h60);
        // R11 INIT with other strobes
        step(0,0,0,0,0,1,2,0,0,0);
        accept('h90, 0);
        step(1,'hC0,1,1,1,1,9,1,'h155,1);
        chk("R11 irq cleared", int'(irq), 0);
        chk("R11 tpr kept", int'(ppr), 'h20);
        step(0,0,0,0,0,0,0,1,'h1AA,0);
        ack();
        chk("R11 sets empty", int'(ack_vector), 'hAA);

        // random phase, collisions on a small vector pool
        for (int n = 0; n < 1500; n++) begin
            int v = (($urandom % 8) << 5) | ($urandom % 3);
            int sd = (($urandom % 5) != 0 ? 'h100 : 0) | ($urandom % 256);
            step(($urandom % 2) == 0, v, ($urandom % 2) == 1, ($urandom % 10) < 3,
                 ($urandom % 4) == 0, ($urandom % 10) == 0, int'($urandom % 16),
                 ($urandom % 32) == 0, sd, ($urandom % 100) == 0);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule